// File: doc/BRIEF.md
# Indexed-Window Watchdog Timer

This block is a watchdog timer whose whole register set sits behind a two-byte I/O window. Byte 0 of the window latches a register index. Byte 1 reads or writes the 8-bit register that the last latched index names. The register set has a run control, an expiry-action selector, a timeout value split over several bytes, and a service register. The service register holds a reload strobe and a sticky expiry flag.

While the timer runs, it counts down once on every cycle where the slow tick-enable input is high. If software does not service it in time, the counter reaches its end. The block then raises a one-clock pulse on either an interrupt-style output or a reset-style output, and records the event in the sticky flag.

Normal use follows a fixed order. Software stops the timer, writes the timeout bytes and the action code, and sets the run bit. After that it writes the reload strobe often enough to keep the counter from expiring.

Top module: `idx_wdt_top`

## Requirements
- R1: A write with `win_sel`=0 latches `win_wdata` as the index. A write with `win_sel`=1 updates the register the index selects. `win_rdata` returns the index when `win_sel`=0 and the selected register when `win_sel`=1.
- R2: Index 0x37 holds the run bit in bit 6, and all its other bits read 0. A write that sets bit 6 while the timer is stopped loads the counter from the timeout value.
- R3: Index 0x38 keeps only its upper nibble, and the lower nibble reads 0. On expiry, code 0xC selects `nmi_o` and code 0xD selects `rst_o`. Any other code asserts neither output.
- R4: The timeout value N is stored least significant byte first at indices 0x39, 0x3A and 0x3B. Expiry happens on the (N+1)th tick after the counter loads.
- R5: The counter changes only on cycles where `tick_en` is high, apart from loads.
- R6: Writing 1 to bit 6 of index 0x3C while the timer runs reloads the counter from the timeout value. This bit always reads 0.
- R7: Bit 7 of index 0x3C is set on expiry. Writing 0 to it clears it, and writing 1 leaves it unchanged. If an expiry and a clear fall in the same cycle, the set wins. All other bits of index 0x3C read 0.
- R8: The selected output is high for exactly one clock, in the cycle after the expiring tick. On expiry the counter reloads from the timeout value and keeps running.
- R9: While the run bit is 0, the counter holds and neither output asserts. Setting the run bit again restarts a full timeout.
- R10: Indices not listed above read 0x00, and writes to them change no register.
- R11: After reset, all registers and the index are 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_sel | input | 1 | Window offset: 0 index byte, 1 data byte |
| win_wr | input | 1 | Write strobe for the window byte |
| win_wdata | input | 8 | Write data |
| win_rdata | output | 8 | Read data of the selected window byte |
| tick_en | input | 1 | Slow count enable (32768 Hz rate) |
| nmi_o | output | 1 | Interrupt-style expiry pulse |
| rst_o | output | 1 | Reset-style expiry pulse |

## Verification
The checker watches several properties on every cycle. It checks that each expiry event produces the output its code selects and sets the sticky flag. It checks that the flag stays set until a clear write, and that every output pulse traces back to an expiry event. It also checks that every load copies the timeout value and that the counter holds when it is stopped or has no tick.

Some behaviours only the bench scenarios can show. These are the register readback masks, the byte order of the timeout, and the exact tick on which expiry lands for small and multi-byte timeouts. They also include the reload that postpones expiry, the restart after a stop, and the set-over-clear race.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] IX_CTRL  = 8'h37;
  localparam logic [7:0] IX_SSEL  = 8'h38;
  localparam logic [7:0] IX_TMO0  = 8'h39;
  localparam logic [7:0] IX_SVC   = 8'h3C;
  localparam int         BIT_RUN    = 6;
  localparam int         BIT_RELOAD = 6;
  localparam int         BIT_FIRED  = 7;
  localparam logic [3:0] CODE_NMI = 4'hC;
  localparam logic [3:0] CODE_RST = 4'hD;

  typedef enum logic [1:0] {ACT_NONE, ACT_NMI, ACT_RST} act_e;

  function automatic act_e decode_action(input logic [3:0] code);
    case (code)
      CODE_NMI: return ACT_NMI;
      CODE_RST: return ACT_RST;
      default:  return ACT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wdt_regbank.sv
module wdt_regbank
  import wdt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_sel,
  input  logic             win_wr,
  input  logic [7:0]       win_wdata,
  input  logic             expire_evt,
  output logic [7:0]       win_rdata,
  output logic             run_en,
  output logic [3:0]       ssel_code,
  output logic [CNT_W-1:0] tmo,
  output logic             load_req,
  output logic             fired,
  output logic             fired_clr
);
  localparam int NB = (CNT_W + 7) / 8;

  logic [7:0]      idx_q;
  logic [7:0]      tmo_b [NB];
  logic [NB*8-1:0] tmo_flat;

  wire data_wr   = win_wr & win_sel;
  wire idx_wr    = win_wr & ~win_sel;
  wire hit_ctrl  = data_wr && (idx_q == IX_CTRL);
  wire hit_ssel  = data_wr && (idx_q == IX_SSEL);
  wire hit_svc   = data_wr && (idx_q == IX_SVC);
  wire reload_pl = hit_svc && win_wdata[BIT_RELOAD];
  wire start_pl  = hit_ctrl && win_wdata[BIT_RUN] && !run_en;

  assign fired_clr = hit_svc && !win_wdata[BIT_FIRED];
  assign load_req  = start_pl || (reload_pl && run_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      run_en    <= 1'b0;
      ssel_code <= '0;
      fired     <= 1'b0;
    end else begin
      if (idx_wr)   idx_q     <= win_wdata;
      if (hit_ctrl) run_en    <= win_wdata[BIT_RUN];
      if (hit_ssel) ssel_code <= win_wdata[7:4];
      if (expire_evt)     fired <= 1'b1;
      else if (fired_clr) fired <= 1'b0;
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_tmo
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmo_b[k] <= '0;
      else if (data_wr && (idx_q == IX_TMO0 + 8'(k))) tmo_b[k] <= win_wdata;
    end
    assign tmo_flat[k*8 +: 8] = tmo_b[k];
  end

  assign tmo = tmo_flat[CNT_W-1:0];

  always_comb begin
    win_rdata = 8'h00;
    if (!win_sel) begin
      win_rdata = idx_q;
    end else begin
      case (idx_q)
        IX_CTRL: win_rdata[BIT_RUN]   = run_en;
        IX_SSEL: win_rdata[7:4]       = ssel_code;
        IX_SVC:  win_rdata[BIT_FIRED] = fired;
        default: begin
          for (int k = 0; k < NB; k++)
            if (idx_q == IX_TMO0 + 8'(k)) win_rdata = tmo_b[k];
        end
      endcase
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick_en,
  input  logic             load_req,
  input  logic [CNT_W-1:0] tmo,
  output logic [CNT_W-1:0] cnt,
  output logic             expire_evt
);
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] top);
    return (cur == '0) ? top : cur - 1'b1;
  endfunction

  wire step = run_en && tick_en && !load_req;
  assign expire_evt = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load_req) cnt <= tmo;
    else if (step)     cnt <= next_count(cnt, tmo);
  end
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire_evt,
  input  logic [3:0] ssel_code,
  output logic       nmi_o,
  output logic       rst_o
);
  act_e act;
  assign act = decode_action(ssel_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_o <= 1'b0;
      rst_o <= 1'b0;
    end else begin
      nmi_o <= expire_evt && (act == ACT_NMI);
      rst_o <= expire_evt && (act == ACT_RST);
    end
  end
endmodule

// File: rtl/idx_wdt_top.sv
module idx_wdt_top #(
  parameter int CNT_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_sel,
  input  logic       win_wr,
  input  logic [7:0] win_wdata,
  output logic [7:0] win_rdata,
  input  logic       tick_en,
  output logic       nmi_o,
  output logic       rst_o
);
  logic             run_en;
  logic [3:0]       ssel_code;
  logic [CNT_W-1:0] tmo;
  logic [CNT_W-1:0] cnt;
  logic             load_req;
  logic             fired;
  logic             fired_clr;
  logic             expire_evt;

  wdt_regbank #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .win_wr(win_wr),
    .win_wdata(win_wdata), .expire_evt(expire_evt), .win_rdata(win_rdata),
    .run_en(run_en), .ssel_code(ssel_code), .tmo(tmo), .load_req(load_req),
    .fired(fired), .fired_clr(fired_clr)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_en(tick_en),
    .load_req(load_req), .tmo(tmo), .cnt(cnt), .expire_evt(expire_evt)
  );

  wdt_expiry u_exp (
    .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt),
    .ssel_code(ssel_code), .nmi_o(nmi_o), .rst_o(rst_o)
  );
endmodule

// File: rtl/idx_wdt_checker.sv
module idx_wdt_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             run_en,
  input logic [3:0]       ssel_code,
  input logic [CNT_W-1:0] tmo,
  input logic [CNT_W-1:0] cnt,
  input logic             load_req,
  input logic             fired,
  input logic             fired_clr,
  input logic             expire_evt,
  input logic             nmi_o,
  input logic             rst_o
);
  AST_NMI_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && ssel_code == 4'hC |=> nmi_o && !rst_o); // R3
  AST_RST_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && ssel_code == 4'hD |=> rst_o && !nmi_o); // R3
  AST_OUT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o || rst_o) |-> $past(expire_evt)); // R8
  AST_FIRED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> fired); // R7
  AST_FIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fired && !fired_clr |=> fired); // R7
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> cnt == $past(tmo)); // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !load_req |=> $stable(cnt)); // R9
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !load_req |=> $stable(cnt)); // R5
endmodule

bind idx_wdt_top idx_wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
  .ssel_code(ssel_code), .tmo(tmo), .cnt(cnt), .load_req(load_req),
  .fired(fired), .fired_clr(fired_clr), .expire_evt(expire_evt),
  .nmi_o(nmi_o), .rst_o(rst_o)
);

// File: tb/idx_wdt_top_bench.sv
module idx_wdt_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {index, write data, expected readback}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h38, 8'hFF, 8'hF0}, {8'h38, 8'hC3, 8'hC0}, {8'h39, 8'hA5, 8'hA5},
    {8'h3A, 8'h5A, 8'h5A}, {8'h3B, 8'h3C, 8'h3C}, {8'h3C, 8'hFF, 8'h00},
    {8'h40, 8'h77, 8'h00}, {8'h00, 8'hFF, 8'h00}, {8'h36, 8'h12, 8'h00},
    {8'h3D, 8'h99, 8'h00}, {8'h37, 8'hC1, 8'h40}, {8'h37, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_sel = 1'b0;
  logic win_wr = 1'b0;
  logic [7:0] win_wdata = '0;
  logic [7:0] win_rdata;
  logic tick_en = 1'b0;
  logic nmi_o, rst_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_wdt_top u_idx_wdt_top (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .win_wr(win_wr),
    .win_wdata(win_wdata), .win_rdata(win_rdata), .tick_en(tick_en),
    .nmi_o(nmi_o), .rst_o(rst_o)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic en, input logic er);
    checks++;
    if (nmi_o !== en || rst_o !== er) begin
      errors++;
      $display("FAIL %s: actual nmi=%b rst=%b expected nmi=%b rst=%b",
               req, nmi_o, rst_o, en, er);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_port(input logic sel, input logic [7:0] d);
    win_sel = sel; win_wr = 1'b1; win_wdata = d;
    @(posedge clk); @(negedge clk);
    win_wr = 1'b0; win_sel = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
    wr_port(1'b0, ix);
    wr_port(1'b1, d);
  endtask

  task automatic rd_reg(input logic [7:0] ix, output logic [7:0] d);
    wr_port(1'b0, ix);
    win_sel = 1'b1;
    #1 d = win_rdata;
    win_sel = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic cfg(input logic [23:0] n, input logic [7:0] code);
    wr_reg(8'h37, 8'h00);
    wr_reg(8'h39, n[7:0]);
    wr_reg(8'h3A, n[15:8]);
    wr_reg(8'h3B, n[23:16]);
    wr_reg(8'h38, code);
    wr_reg(8'h37, 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check_out("R11 outputs", 1'b0, 1'b0);
    #1 check8("R11 index", win_rdata, 8'h00);
    rd_reg(8'h37, v); check8("R11 ctrl", v, 8'h00);
    rd_reg(8'h3C, v); check8("R11 svc", v, 8'h00);
    rd_reg(8'h39, v); check8("R11 tmo0", v, 8'h00);

    // R1 R2 R3 R4 R6 R10 register table
    for (int i = 0; i < NVEC; i++) begin
      wr_reg(VEC[i][23:16], VEC[i][15:8]);
      rd_reg(VEC[i][23:16], v);
      check8("R1 R2 R3 R4 R6 R10 readback", v, VEC[i][7:0]);
      #1 check8("R1 index port", win_rdata, VEC[i][23:16]);
    end

    // R4 R3 R8: N=2 gives expiry on third tick, NMI code
    cfg(24'd2, 8'hC0);
    run_ticks(2); check_out("R4 no early expiry", 1'b0, 1'b0);
    run_ticks(1); check_out("R4 R3 nmi on third tick", 1'b1, 1'b0);
    idle(1);      check_out("R8 single clock pulse", 1'b0, 1'b0);
    rd_reg(8'h3C, v); check8("R7 fired set", v, 8'h80);
    wr_reg(8'h3C, 8'h80);
    rd_reg(8'h3C, v); check8("R7 write 1 keeps", v, 8'h80);
    run_ticks(2); check_out("R8 reload after expiry", 1'b0, 1'b0);
    run_ticks(1); check_out("R8 periodic expiry", 1'b1, 1'b0);
    wr_reg(8'h3C, 8'h00);
    rd_reg(8'h3C, v); check8("R7 write 0 clears", v, 8'h00);

    // R6 reload postpones expiry
    run_ticks(2);
    wr_reg(8'h3C, 8'hC0);
    run_ticks(2); check_out("R6 reload postpones", 1'b0, 1'b0);
    run_ticks(1); check_out("R6 expiry after reload", 1'b1, 1'b0);

    // R3 reset action
    cfg(24'd1, 8'hD0);
    run_ticks(1); check_out("R3 reset not yet", 1'b0, 1'b0);
    run_ticks(1); check_out("R3 reset pulse", 1'b0, 1'b1);

    // R9 hold while stopped, restart full
    cfg(24'd1, 8'hD0);
    run_ticks(1);
    wr_reg(8'h37, 8'h00);
    run_ticks(3); check_out("R9 stopped no output", 1'b0, 1'b0);
    wr_reg(8'h37, 8'h40);
    run_ticks(1); check_out("R9 full restart", 1'b0, 1'b0);
    run_ticks(1); check_out("R9 expiry after restart", 1'b0, 1'b1);

    // R5 no count without tick
    cfg(24'd0, 8'hC0);
    idle(5);      check_out("R5 no tick no expiry", 1'b0, 1'b0);
    run_ticks(1); check_out("R5 first tick expires", 1'b1, 1'b0);

    // R3 unknown code: no output, flag still set
    wr_reg(8'h3C, 8'h00);
    cfg(24'd0, 8'hE0);
    run_ticks(1); check_out("R3 unknown code silent", 1'b0, 1'b0);
    rd_reg(8'h3C, v); check8("R3 R7 fired on silent expiry", v, 8'h80);

    // R7 set wins over simultaneous clear
    wr_reg(8'h3C, 8'h00);
    cfg(24'd0, 8'hC0);
    wr_port(1'b0, 8'h3C);
    win_sel = 1'b1; win_wr = 1'b1; win_wdata = 8'h00; tick_en = 1'b1;
    @(posedge clk); @(negedge clk);
    win_sel = 1'b0; win_wr = 1'b0; tick_en = 1'b0;
    check_out("R7 race expiry", 1'b1, 1'b0);
    rd_reg(8'h3C, v); check8("R7 set wins", v, 8'h80);

    // R4 byte order: middle and upper bytes
    cfg(24'h000100, 8'hC0);
    run_ticks(256); check_out("R4 256 ticks quiet", 1'b0, 1'b0);
    run_ticks(1);   check_out("R4 expiry at 257", 1'b1, 1'b0);
    cfg(24'h010000, 8'hC0);
    run_ticks(65536); check_out("R4 65536 ticks quiet", 1'b0, 1'b0);
    run_ticks(1);     check_out("R4 expiry at 65537", 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule